// File: doc/BRIEF.md
# Block-Cipher Register Front End

This block sits between a host bus and a 64-bit block-cipher engine and runs the engine one block at a time. The host loads a key through six 32-bit key registers, picks the mode (single or triple key, ECB or CBC, encrypt or decrypt) in a control register, and writes the two halves of a block into two data registers. Writing the second half starts the engine. When the result is ready, the host reads both halves back from the same two addresses. Reading the second half hands the block back and re-arms the input side.

CBC chaining is done inside the block. On encryption the IV is XORed into the plaintext and replaced by the ciphertext. On decryption the engine output is XORed with the IV and the IV is replaced by the incoming ciphertext. The IV registers therefore always read back the chaining value for the next request.

Two interrupt sources are provided: input-ready and output-ready. They are held in a status register that the host clears by writing ones, and gated by an enable register. A byte-length counter together with two mask bits drives an input and an output request line for an external DMA engine. The cipher itself is replaced by a latency-parameterised stub. Its encrypt transform is XOR with the key, then a one-bit left rotate of the 64-bit block. Its decrypt transform is a one-bit right rotate, then XOR with the key.

Top module: `blkc_regfront`

## Requirements
- R1: After reset the control register reads 0x02 (input ready, all mode bits 0), IRQ status reads 0x02, IRQ enable, length and mask read 0, and irq, dma_in_req and dma_out_req are 0.
- R2: The control register at 0x20 stores CBC in bit 4, triple-key in bit 3 and encrypt in bit 2. Bit 1 reads 1 while input is accepted, and bit 0 reads 1 while a result is waiting. Writes to bits 1 and 0 have no effect.
- R3: Key word i (i = 0..5) is written at address 0x14 − (i XOR 1)·4, so words 0..5 sit at 0x10, 0x14, 0x08, 0x0C, 0x00, 0x04. The 64-bit key is {w0,w1} in single-key mode and {w0,w1}^{w2,w3}^{w4,w5} in triple-key mode. A block is {word at 0x28, word at 0x2C}, with the first word as the upper half. ECB encrypt returns rotl1(block ^ key) and ECB decrypt returns rotr1(block) ^ key.
- R4: A write to 0x2C while input-ready starts a block, and both ready flags drop. Output-ready rises exactly LAT clock edges after the starting edge. A read of 0x2C while output-ready returns to input-ready.
- R5: Writes to 0x28 or 0x2C while not input-ready are ignored and do not alter the result returned.
- R6: In CBC encryption the engine input is plaintext ^ IV, and the IV (0x18 upper, 0x1C lower) becomes the ciphertext.
- R7: In CBC decryption the result is engine output ^ IV, and the IV becomes the incoming ciphertext.
- R8: In ECB mode the IV registers are left unchanged by block processing.
- R9: IRQ status bit 1 sets on entering input-ready and bit 2 sets on entering output-ready. Writing 1 to a status bit at 0x3C clears it, and a set in the same cycle wins. irq is high when any status bit is set and its matching enable bit at 0x40 is also set.
- R10: The length register at 0x24 drops by 8 each time a result is read out (read of 0x2C), and stays at 0 once it reaches 0.
- R11: dma_in_req is high exactly when mask bit 5 (at 0x34) is set, length is nonzero and input is ready. dma_out_req is high exactly when mask bit 6 is set, length is nonzero and a result is waiting.
- R12: The revision register at 0x30 returns REV_MAJOR in bits 10:8 and REV_MINOR in bits 5:0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on 0x2C) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |
| dma_in_req | output | 1 | Request for the next input block |
| dma_out_req | output | 1 | Request to drain a result block |

## Verification
The bench goes after the exact cycle in which output-ready rises. A design with an off-by-one counter would show the result a cycle early or late. The bench also runs two-block CBC chains in both directions and decrypts its own ciphertext. A design that chained the wrong value, or XORed the IV on the wrong side of the engine, would fail to restore the plaintext or would leave a stale IV. It further probes data writes while busy, the write-one clear racing a status set, and the length counter reaching and staying at zero. A design that restarted on a stray write, lost a status set, or wrapped the counter would drive a spurious interrupt or DMA request. Those request lines are compared against a behavioural model on every clock.

// File: rtl/blkc_pkg.sv
// Shared constants, state type and stub cipher transforms for the
// block-cipher register front end. Assumes a 64-bit block made of two
// 32-bit bus words.
package blkc_pkg;
    parameter int ADDR_W  = 8;
    parameter int WORD_W  = 32;
    parameter int BLK_W   = 2 * WORD_W;
    parameter int NKEY    = 6;

    parameter logic [ADDR_W-1:0] A_KEYBASE = 8'h14;
    parameter logic [ADDR_W-1:0] A_IV0     = 8'h18;
    parameter logic [ADDR_W-1:0] A_IV1     = 8'h1C;
    parameter logic [ADDR_W-1:0] A_CTRL    = 8'h20;
    parameter logic [ADDR_W-1:0] A_LEN     = 8'h24;
    parameter logic [ADDR_W-1:0] A_DATA0   = 8'h28;
    parameter logic [ADDR_W-1:0] A_DATA1   = 8'h2C;
    parameter logic [ADDR_W-1:0] A_REV     = 8'h30;
    parameter logic [ADDR_W-1:0] A_MASK    = 8'h34;
    parameter logic [ADDR_W-1:0] A_STAT    = 8'h3C;
    parameter logic [ADDR_W-1:0] A_IEN     = 8'h40;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_BUSY  = 2'd1,
        ST_DONE  = 2'd2
    } blk_state_e;

    // Stub forward transform: key mix, then one-bit left rotate.
    function automatic logic [BLK_W-1:0] stub_fwd(input logic [BLK_W-1:0] x,
                                                  input logic [BLK_W-1:0] k);
        logic [BLK_W-1:0] t;
        t = x ^ k;
        return {t[BLK_W-2:0], t[BLK_W-1]};
    endfunction

    // Stub inverse transform: one-bit right rotate, then key mix.
    function automatic logic [BLK_W-1:0] stub_inv(input logic [BLK_W-1:0] x,
                                                  input logic [BLK_W-1:0] k);
        return {x[0], x[BLK_W-1:1]} ^ k;
    endfunction
endpackage

// File: rtl/blkc_keybank.sv
// Key register bank. Holds NKEY bus words at descending, pair-swapped
// addresses and folds them into one block-wide key: the first pair alone
// in single-key mode, all pairs XORed in triple-key mode.
// Assumes NKEY is even and at least 2.
module blkc_keybank
    import blkc_pkg::*;
#(
    parameter int N_WORDS = NKEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              triple,
    output logic [BLK_W-1:0]  key_mix
);
    localparam int N_PAIRS = N_WORDS / 2;

    logic [WORD_W-1:0] key_q [N_WORDS];

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        localparam logic [ADDR_W-1:0] WADDR =
            ADDR_W'(int'(A_KEYBASE) - ((i ^ 1) * 4));
        // Capture key word i when its own address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                key_q[i] <= '0;
            else if (wr_en && addr == WADDR)
                key_q[i] <= wdata;
        end
    end

    // Fold the stored pairs into the key the engine uses.
    always_comb begin
        key_mix = {key_q[0], key_q[1]};
        if (triple) begin
            for (int p = 1; p < N_PAIRS; p++)
                key_mix = key_mix ^ {key_q[2*p], key_q[2*p+1]};
        end
    end
endmodule

// File: rtl/blkc_core_stub.sv
// Stand-in for the cipher engine. Captures a block, key and direction
// on start and raises done for one cycle LAT edges later, with the
// transformed block on blk_out. Assumes LAT >= 1 and no start while busy.
module blkc_core_stub
    import blkc_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_enc,
    input  logic [BLK_W-1:0] blk_in,
    input  logic [BLK_W-1:0] key_in,
    output logic             done,
    output logic [BLK_W-1:0] blk_out
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BLK_W-1:0] data_q;
    logic [BLK_W-1:0] key_q;
    logic             dir_q;

    // Latency counter: load on start, count down, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(LAT - 1);
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Operand capture at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            key_q  <= '0;
            dir_q  <= 1'b0;
        end else if (start) begin
            data_q <= blk_in;
            key_q  <= key_in;
            dir_q  <= dir_enc;
        end
    end

    assign done    = busy_q && (cnt_q == '0);
    assign blk_out = dir_q ? stub_fwd(data_q, key_q) : stub_inv(data_q, key_q);
endmodule

// File: rtl/blkc_regfront.sv
// Memory-mapped front end for a 64-bit block cipher. Decodes the
// register map, sequences one block at a time (ready -> busy -> done),
// applies CBC chaining around the engine, keeps write-one-to-clear
// interrupt status and drives DMA request lines from a byte counter.
// Assumes single-cycle bus accesses; a read of the second data word
// while a result waits is the hand-back of that result.
module blkc_regfront
    import blkc_pkg::*;
#(
    parameter int          LAT       = 4,
    parameter int unsigned REV_MAJOR = 2,
    parameter int unsigned REV_MINOR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              dma_in_req,
    output logic              dma_out_req
);
    localparam int BLK_BYTES = BLK_W / 8;
    localparam logic [WORD_W-1:0] LEN_STEP = WORD_W'(BLK_BYTES);

    blk_state_e        st_q;
    logic              ctrl_cbc, ctrl_tdes, ctrl_enc;
    logic              run_cbc, run_enc;
    logic [WORD_W-1:0] din0_q;
    logic [BLK_W-1:0]  res_q, iv_q, ct_q;
    logic [WORD_W-1:0] len_q;
    logic              dma_in_en, dma_out_en;
    logic              stat_in_q, stat_out_q;
    logic              en_in_q, en_out_q;

    logic              start, hand_back, core_done;
    logic [BLK_W-1:0]  blk_new, core_in, core_out, key_mix;

    assign start     = bus_wr && bus_addr == A_DATA1 && st_q == ST_READY;
    assign hand_back = bus_rd && bus_addr == A_DATA1 && st_q == ST_DONE;
    assign blk_new   = {din0_q, bus_wdata};
    assign core_in   = (ctrl_cbc && ctrl_enc) ? (blk_new ^ iv_q) : blk_new;

    blkc_keybank u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .triple  (ctrl_tdes),
        .key_mix (key_mix)
    );

    blkc_core_stub #(.LAT(LAT)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .dir_enc (ctrl_enc),
        .blk_in  (core_in),
        .key_in  (key_mix),
        .done    (core_done),
        .blk_out (core_out)
    );

    // Block sequencer: ready -> busy on start, busy -> done on engine
    // completion, done -> ready on hand-back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_READY;
        else if (start)
            st_q <= ST_BUSY;
        else if (core_done)
            st_q <= ST_DONE;
        else if (hand_back)
            st_q <= ST_READY;
    end

    // Mode control register and the mode latched for the running block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_cbc  <= 1'b0;
            ctrl_tdes <= 1'b0;
            ctrl_enc  <= 1'b0;
            run_cbc   <= 1'b0;
            run_enc   <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) begin
                ctrl_cbc  <= bus_wdata[4];
                ctrl_tdes <= bus_wdata[3];
                ctrl_enc  <= bus_wdata[2];
            end
            if (start) begin
                run_cbc <= ctrl_cbc;
                run_enc <= ctrl_enc;
            end
        end
    end

    // First data word and the incoming block kept for CBC decryption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din0_q <= '0;
            ct_q   <= '0;
        end else begin
            if (bus_wr && bus_addr == A_DATA0 && st_q == ST_READY)
                din0_q <= bus_wdata;
            if (start)
                ct_q <= blk_new;
        end
    end

    // Result register and IV chaining; engine completion beats host IV writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            iv_q  <= '0;
        end else if (core_done) begin
            res_q <= (run_cbc && !run_enc) ? (core_out ^ iv_q) : core_out;
            if (run_cbc)
                iv_q <= run_enc ? core_out : ct_q;
        end else if (bus_wr && bus_addr == A_IV0) begin
            iv_q[BLK_W-1:WORD_W] <= bus_wdata;
        end else if (bus_wr && bus_addr == A_IV1) begin
            iv_q[WORD_W-1:0] <= bus_wdata;
        end
    end

    // Byte length counter and DMA mask bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q      <= '0;
            dma_in_en  <= 1'b0;
            dma_out_en <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_LEN)
                len_q <= bus_wdata;
            else if (hand_back)
                len_q <= (len_q >= LEN_STEP) ? (len_q - LEN_STEP) : '0;
            if (bus_wr && bus_addr == A_MASK) begin
                dma_in_en  <= bus_wdata[5];
                dma_out_en <= bus_wdata[6];
            end
        end
    end

    // Interrupt status (set by events, write-one clear, set wins) and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_in_q  <= 1'b1;
            stat_out_q <= 1'b0;
            en_in_q    <= 1'b0;
            en_out_q   <= 1'b0;
        end else begin
            if (hand_back)
                stat_in_q <= 1'b1;
            else if (bus_wr && bus_addr == A_STAT && bus_wdata[1])
                stat_in_q <= 1'b0;
            if (core_done)
                stat_out_q <= 1'b1;
            else if (bus_wr && bus_addr == A_STAT && bus_wdata[2])
                stat_out_q <= 1'b0;
            if (bus_wr && bus_addr == A_IEN) begin
                en_in_q  <= bus_wdata[1];
                en_out_q <= bus_wdata[2];
            end
        end
    end

    // Register read multiplexer; key words read as zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_IV0:   bus_rdata = iv_q[BLK_W-1:WORD_W];
            A_IV1:   bus_rdata = iv_q[WORD_W-1:0];
            A_CTRL: begin
                bus_rdata[4] = ctrl_cbc;
                bus_rdata[3] = ctrl_tdes;
                bus_rdata[2] = ctrl_enc;
                bus_rdata[1] = (st_q == ST_READY);
                bus_rdata[0] = (st_q == ST_DONE);
            end
            A_LEN:   bus_rdata = len_q;
            A_DATA0: bus_rdata = res_q[BLK_W-1:WORD_W];
            A_DATA1: bus_rdata = res_q[WORD_W-1:0];
            A_REV: begin
                bus_rdata[10:8] = 3'(REV_MAJOR);
                bus_rdata[5:0]  = 6'(REV_MINOR);
            end
            A_MASK: begin
                bus_rdata[6] = dma_out_en;
                bus_rdata[5] = dma_in_en;
            end
            A_STAT: begin
                bus_rdata[2] = stat_out_q;
                bus_rdata[1] = stat_in_q;
            end
            A_IEN: begin
                bus_rdata[2] = en_out_q;
                bus_rdata[1] = en_in_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq         = (stat_in_q && en_in_q) || (stat_out_q && en_out_q);
    assign dma_in_req  = dma_in_en  && (len_q != '0) && (st_q == ST_READY);
    assign dma_out_req = dma_out_en && (len_q != '0) && (st_q == ST_DONE);
endmodule

// File: rtl/blkc_regfront_chk.sv
// Property checker for blkc_regfront, attached by bind. Observes bus
// inputs, outputs and the sequencer, chaining and status state.
module blkc_regfront_chk
    import blkc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wd_bit2,
    input logic              irq,
    input logic              dma_in_req,
    input logic              dma_out_req,
    input blk_state_e        st_q,
    input logic              core_done,
    input logic              run_cbc,
    input logic              run_enc,
    input logic [WORD_W-1:0] din0_q,
    input logic [BLK_W-1:0]  iv_q,
    input logic [BLK_W-1:0]  res_q,
    input logic [WORD_W-1:0] len_q,
    input logic              stat_out_q,
    input logic              en_in_q,
    input logic              en_out_q
);
    AST_START_LEAVES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DATA1 && st_q == ST_READY) |=> (st_q == ST_BUSY)); // R4

    AST_DATA_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DATA0 && st_q != ST_READY) |=> $stable(din0_q)); // R5

    AST_CBC_ENC_IV_IS_CT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && run_cbc && run_enc) |=> (iv_q == res_q)); // R6

    AST_ECB_IV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !run_cbc) |=> $stable(iv_q)); // R8

    AST_W1C_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STAT && wd_bit2 && !core_done) |=> !stat_out_q); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_in_q && !en_out_q) |-> !irq); // R9

    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_DATA1 && st_q == ST_DONE &&
         !(bus_wr && bus_addr == A_LEN) && len_q >= 32'd8)
        |=> (len_q == $past(len_q) - 32'd8)); // R10

    AST_DMA_NEEDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q == '0) |-> (!dma_in_req && !dma_out_req)); // R11
endmodule

bind blkc_regfront blkc_regfront_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .wd_bit2     (bus_wdata[2]),
    .irq         (irq),
    .dma_in_req  (dma_in_req),
    .dma_out_req (dma_out_req),
    .st_q        (st_q),
    .core_done   (core_done),
    .run_cbc     (run_cbc),
    .run_enc     (run_enc),
    .din0_q      (din0_q),
    .iv_q        (iv_q),
    .res_q       (res_q),
    .len_q       (len_q),
    .stat_out_q  (stat_out_q),
    .en_in_q     (en_in_q),
    .en_out_q    (en_out_q)
);

// File: tb/sim_blkc_regfront.sv
// Self-checking bench: bus tasks with expected values from the
// requirements, plus a behavioural model of state, status, length and
// mask that is compared with irq and the DMA lines on every clock.
module sim_blkc_regfront;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, dma_in_req, dma_out_req;

    int nvec = 0, nerr = 0;
    bit chk_on = 1'b0;

    blkc_regfront #(.LAT(LAT), .REV_MAJOR(2), .REV_MINOR(5)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural model ----------------
    int          m_st = 0;      // 0 ready, 1 busy, 2 done
    int          m_rem = 0;
    bit          m_sin = 1'b1, m_sout = 1'b0;
    bit [1:0]    m_en = '0;     // [0] = enable bit1, [1] = enable bit2
    bit [1:0]    m_mask = '0;   // [0] = mask bit5, [1] = mask bit6
    logic [31:0] m_len = '0;

    always @(posedge clk) begin
        bit set_in, set_out;
        set_in = 1'b0;
        set_out = 1'b0;
        if (!rst_n) begin
            m_st <= 0; m_rem <= 0; m_sin <= 1'b1; m_sout <= 1'b0;
            m_en <= '0; m_mask <= '0; m_len <= '0;
        end else begin
            case (m_st)
                0: if (bus_wr && bus_addr == 8'h2C) begin m_st <= 1; m_rem <= LAT; end
                1: if (m_rem == 1) begin m_st <= 2; set_out = 1'b1; end
                   else m_rem <= m_rem - 1;
                default: if (bus_rd && bus_addr == 8'h2C) begin
                    m_st <= 0; set_in = 1'b1;
                end
            endcase
            if (set_in) m_sin <= 1'b1;
            else if (bus_wr && bus_addr == 8'h3C && bus_wdata[1]) m_sin <= 1'b0;
            if (set_out) m_sout <= 1'b1;
            else if (bus_wr && bus_addr == 8'h3C && bus_wdata[2]) m_sout <= 1'b0;
            if (bus_wr && bus_addr == 8'h40) m_en <= {bus_wdata[2], bus_wdata[1]};
            if (bus_wr && bus_addr == 8'h34) m_mask <= {bus_wdata[6], bus_wdata[5]};
            if (bus_wr && bus_addr == 8'h24) m_len <= bus_wdata;
            else if (set_in) m_len <= (m_len >= 8) ? m_len - 8 : 32'd0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the interrupt and DMA lines (R9, R11).
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R9 irq per-clock", {63'd0, irq},
                {63'd0, (m_sin && m_en[0]) || (m_sout && m_en[1])});
            chk("R11 dma_in_req per-clock", {63'd0, dma_in_req},
                {63'd0, m_mask[0] && m_len != 0 && m_st == 0});
            chk("R11 dma_out_req per-clock", {63'd0, dma_out_req},
                {63'd0, m_mask[1] && m_len != 0 && m_st == 2});
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(tag, {32'd0, v}, {32'd0, exp});
    endtask

    task automatic run_blk(input logic [63:0] d, input logic [63:0] exp, input string tag);
        logic [31:0] v0, v1;
        wr(8'h28, d[63:32]);
        wr(8'h2C, d[31:0]);
        repeat (LAT) @(negedge clk);
        rd(8'h28, v0);
        rd(8'h2C, v1);
        chk(tag, {v0, v1}, exp);
    endtask

    // ---------------- expected-value helpers ----------------
    function automatic logic [63:0] f_enc(input logic [63:0] x, input logic [63:0] k);
        logic [63:0] t;
        t = x ^ k;
        return {t[62:0], t[63]};
    endfunction

    function automatic logic [63:0] f_dec(input logic [63:0] x, input logic [63:0] k);
        return {x[0], x[63:1]} ^ k;
    endfunction

    function automatic logic [7:0] key_addr(input int i);
        return 8'(8'h14 - ((i ^ 1) * 4));
    endfunction

    logic [31:0] kw [6] = '{32'h01234567, 32'h89ABCDEF, 32'h0F1E2D3C,
                            32'h4B5A6978, 32'h11223344, 32'h55667788};

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog R4 sequencing hung actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [63:0] k1, k3, iv0, p1, p2, c1, c2, blk;
        logic [31:0] v;
        k1 = {kw[0], kw[1]};
        k3 = k1 ^ {kw[2], kw[3]} ^ {kw[4], kw[5]};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R1 reset state
        rd_chk(8'h20, 32'h02, "R1 ctrl after reset");
        rd_chk(8'h3C, 32'h02, "R1 status after reset");
        rd_chk(8'h40, 32'h00, "R1 enable after reset");
        rd_chk(8'h24, 32'h00, "R1 length after reset");
        rd_chk(8'h34, 32'h00, "R1 mask after reset");
        // R12 revision
        rd_chk(8'h30, 32'h0000_0205, "R12 revision");

        // R3 key words at pair-swapped descending addresses
        for (int i = 0; i < 6; i++) wr(key_addr(i), kw[i]);

        // R2 control fields; ready bits not writable
        wr(8'h20, 32'h1F);
        rd_chk(8'h20, 32'h1E, "R2 ctrl readback with ready bits written");
        wr(8'h20, 32'h04);
        rd_chk(8'h20, 32'h06, "R2 ctrl ECB encrypt single");

        // R4 start and exact output-ready timing, R3 single-key encrypt
        blk = 64'hDEADBEEF_00C0FFEE;
        wr(8'h28, blk[63:32]);
        wr(8'h2C, blk[31:0]);
        for (int j = 0; j <= LAT; j++) begin
            rd(8'h20, v);
            chk("R4 ready flags while running", {62'd0, v[1:0]},
                {62'd0, (j == LAT) ? 2'b01 : 2'b00});
        end
        rd_chk(8'h28, f_enc(blk, k1) >> 32, "R3 ECB single encrypt upper");
        rd_chk(8'h2C, f_enc(blk, k1) & 64'hFFFF_FFFF, "R3 ECB single encrypt lower");
        rd_chk(8'h20, 32'h06, "R4 ready again after hand-back");

        // R5 writes to data words while busy or done are ignored
        blk = 64'h13579BDF_2468ACE0;
        wr(8'h28, blk[63:32]);
        wr(8'h2C, blk[31:0]);
        wr(8'h28, 32'hFFFF_0000);
        wr(8'h2C, 32'h0000_FFFF);
        repeat (LAT) @(negedge clk);
        wr(8'h28, 32'hAAAA_5555);
        wr(8'h2C, 32'h5555_AAAA);
        rd_chk(8'h20, 32'h05, "R5 still output-ready after ignored writes");
        rd_chk(8'h28, f_enc(blk, k1) >> 32, "R5 result upper unchanged");
        rd_chk(8'h2C, f_enc(blk, k1) & 64'hFFFF_FFFF, "R5 result lower unchanged");

        // R3 triple-key ECB decrypt; R8 IV kept in ECB
        iv0 = 64'hA5A5A5A5_5A5A5A5A;
        wr(8'h18, iv0[63:32]);
        wr(8'h1C, iv0[31:0]);
        wr(8'h20, 32'h08);
        blk = 64'h0BADF00D_CAFEBABE;
        run_blk(blk, f_dec(blk, k3), "R3 ECB triple decrypt");
        rd_chk(8'h18, iv0[63:32], "R8 IV upper kept in ECB");
        rd_chk(8'h1C, iv0[31:0], "R8 IV lower kept in ECB");

        // R6 CBC encrypt, two chained blocks, triple key
        wr(8'h20, 32'h1C);
        p1 = 64'h11111111_22222222;
        p2 = 64'h33333333_44444444;
        c1 = f_enc(p1 ^ iv0, k3);
        c2 = f_enc(p2 ^ c1, k3);
        run_blk(p1, c1, "R6 CBC encrypt block 1");
        run_blk(p2, c2, "R6 CBC encrypt block 2");
        rd_chk(8'h18, c2[63:32], "R6 IV upper is last ciphertext");
        rd_chk(8'h1C, c2[31:0], "R6 IV lower is last ciphertext");

        // R7 CBC decrypt restores plaintext
        wr(8'h18, iv0[63:32]);
        wr(8'h1C, iv0[31:0]);
        wr(8'h20, 32'h18);
        run_blk(c1, p1, "R7 CBC decrypt block 1");
        run_blk(c2, p2, "R7 CBC decrypt block 2");
        rd_chk(8'h18, c2[63:32], "R7 IV upper is last ciphertext in");
        rd_chk(8'h1C, c2[31:0], "R7 IV lower is last ciphertext in");

        // R9 status / enable / write-one clear
        wr(8'h20, 32'h04);
        wr(8'h40, 32'h06);
        rd_chk(8'h3C, 32'h06, "R9 both status bits set after blocks");
        wr(8'h3C, 32'h06);
        rd_chk(8'h3C, 32'h00, "R9 write-one clears both");
        blk = 64'h00000000_00000001;
        wr(8'h28, blk[63:32]);
        wr(8'h2C, blk[31:0]);
        repeat (LAT) @(negedge clk);
        rd_chk(8'h3C, 32'h04, "R9 output status set on result");
        wr(8'h3C, 32'h02);
        rd_chk(8'h3C, 32'h04, "R9 clearing bit1 leaves bit2");
        rd(8'h28, v);
        rd(8'h2C, v);
        chk("R9 result lower", {32'd0, v}, f_enc(blk, k1) & 64'hFFFF_FFFF);
        rd_chk(8'h3C, 32'h06, "R9 input status set on hand-back");
        wr(8'h3C, 32'h04);
        rd_chk(8'h3C, 32'h02, "R9 clearing bit2 leaves bit1");
        wr(8'h40, 32'h00);

        // R10 / R11 length counter and DMA requests
        wr(8'h34, 32'h60);
        wr(8'h24, 32'd16);
        rd_chk(8'h34, 32'h60, "R11 mask readback");
        blk = 64'hFEDCBA98_76543210;
        run_blk(blk, f_enc(blk, k1), "R10 block with length 16");
        rd_chk(8'h24, 32'd8, "R10 length after one block");
        run_blk(blk, f_enc(blk, k1), "R10 block with length 8");
        rd_chk(8'h24, 32'd0, "R10 length reaches zero");
        run_blk(blk, f_enc(blk, k1), "R10 block with length 0");
        rd_chk(8'h24, 32'd0, "R10 length stays at zero");
        wr(8'h24, 32'd5);
        run_blk(blk, f_enc(blk, k1), "R10 block with short length");
        rd_chk(8'h24, 32'd0, "R10 short length saturates");
        wr(8'h34, 32'h00);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule